// File: doc/BRIEF.md
# Two-Wire Debug Port Host Sequencer

This block is the host side of a synchronous two-wire debug link that also has a separate active-low reset line. It drives the debug clock and the reset line, and it shares one bidirectional data line with the target through an output enable. A request interface offers three kinds of job. The first enters debug mode on the target. The second pulses the target reset by itself. The third runs a full command: an opcode, zero to three argument bytes, and then a response of 0 to 16 bits read back from the target.

All pin timing is built from one programmable half-period, counted in system clock cycles. That half-period can be very short for fast links or millions of cycles long for slow ones. Each accepted job raises `busy_o` and ends with a one-cycle `done_o` strobe. The captured response is presented right-aligned on `resp_o`.

Top module: `dbg2w_host`

## Requirements
- R1: After reset and whenever no job runs, `dbg_clk_o`=0, `dbg_rst_no`=1, `dbg_dat_oe_o`=0 and `busy_o`=0. No pin changes until a request is accepted.
- R2: A request of kind 1 (enter debug) produces six pin states, each one half-period long, with (clk,rst_n) taking the values (1,1), (0,0), (1,0), (0,0), (1,0), (0,1). Data is driven high with the enable set for the whole sequence, and `done_o` follows right after the sixth state.
- R3: A request of kind 2 (pin reset) holds `dbg_rst_no` low for exactly one half-period with the clock low, then returns it high and strobes `done_o`.
- R4: A request of kind 0 (command) sends the opcode first, then argument bytes 0, 1 and 2 in that order (byte k taken from `req_args_i[8k+7:8k]`), each most significant bit first. Each bit puts the data on the line, with the enable set, as the clock rises. The clock stays high for one half-period and low for one half-period while the data is held. `dbg_rst_no` stays high.
- R5: After the command bytes, each response bit releases the line (enable 0, `dbg_dat_o`=1) and gives one clock high half-period and one low half-period. The line is sampled at the end of the low half-period and the bit is shifted in from the right. `resp_o` holds the response right-aligned when `done_o` is high. A requested length above 16 is treated as 16.
- R6: When the opcode's upper six bits are 010101 (opcodes 0x54 to 0x57), the number of argument bytes sent is the opcode's low two bits, and `req_nargs_i` is ignored.
- R7: Each half-period lasts max(`half_i`,1) system cycles. The value is captured when the request is accepted, so later changes to `half_i` do not affect the running job.
- R8: `busy_o` rises the cycle after acceptance and falls in the cycle where `done_o` is high. `done_o` lasts one cycle. Requests made while busy, and requests of kind 3, are ignored.
- R9: A command with a response length of 0 completes right after its last sent bit, and `resp_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_i | input | HP_W | Debug half-period in system cycles (0 acts as 1) |
| req_valid_i | input | 1 | Request strobe, taken when not busy |
| req_kind_i | input | 2 | 0 command, 1 enter debug, 2 pin reset, 3 ignored |
| req_opcode_i | input | 8 | Command opcode |
| req_args_i | input | 8*NARG | Argument bytes, byte 0 in the low bits |
| req_nargs_i | input | $clog2(NARG+1) | Number of argument bytes to send |
| req_rbits_i | input | $clog2(RESP_W+1) | Number of response bits to read |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion strobe |
| resp_o | output | RESP_W | Captured response, right-aligned |
| dbg_clk_o | output | 1 | Debug clock |
| dbg_rst_no | output | 1 | Target reset, active low |
| dbg_dat_o | output | 1 | Data line value when driven |
| dbg_dat_oe_o | output | 1 | Data line drive enable |
| dbg_dat_i | input | 1 | Data line as seen at the pad |

## Verification
A wrong phase counter or a wrong bit count shows up as an extra or missing clock pulse, and `done_o` then arrives early or late by a whole number of half-periods. The bench catches this on the first job that has the fault. A transmit shift register that is misloaded or shifts at the wrong time corrupts the bits sent within the first byte. A wrong half-period counter shows as clock runs of the wrong length right at the first clock level. A wrong sample point or shift direction shows as a changed `resp_o` at the `done_o` of the same job.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

  typedef enum logic [1:0] {
    REQ_CMD    = 2'd0,
    REQ_ENTER  = 2'd1,
    REQ_PINRST = 2'd2,
    REQ_NONE   = 2'd3
  } req_kind_e;

  // opcodes whose low two bits carry the argument count
  localparam logic [5:0] INJ_PREFIX = 6'b010101;

  typedef struct packed {
    logic clk;
    logic rst_n;
    logic oe;
  } pins_t;

  localparam pins_t PINS_IDLE = '{clk: 1'b0, rst_n: 1'b1, oe: 1'b0};

endpackage

// File: rtl/dbg2w_tick.sv
module dbg2w_tick #(
  parameter int HP_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            run_i,
  input  logic [HP_W-1:0] half_i,
  output logic            tick_o
);

  logic [HP_W-1:0] hp_q, cnt_q;

  assign tick_o = run_i && (cnt_q == hp_q - HP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hp_q  <= HP_W'(1);
      cnt_q <= '0;
    end else if (start_i) begin
      hp_q  <= (half_i == '0) ? HP_W'(1) : half_i;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + HP_W'(1);
    end
  end

endmodule

// File: rtl/dbg2w_shift.sv
module dbg2w_shift #(
  parameter int FRAME_W = 32,
  parameter int RESP_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  input  logic               sample_i,
  input  logic               dat_i,
  output logic               tx_bit_o,
  output logic [RESP_W-1:0]  rx_o
);

  logic [FRAME_W-1:0] tx_q;
  logic [RESP_W-1:0]  rx_q;

  assign tx_bit_o = tx_q[FRAME_W-1];
  assign rx_o     = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '1;
      rx_q <= '0;
    end else if (start_i) begin
      tx_q <= frame_i;
      rx_q <= '0;
    end else begin
      if (shift_i)  tx_q <= {tx_q[FRAME_W-2:0], 1'b1};
      if (sample_i) rx_q <= {rx_q[RESP_W-2:0], dat_i};
    end
  end

endmodule

// File: rtl/dbg2w_seq.sv
module dbg2w_seq
  import dbg2w_pkg::*;
#(
  parameter int NB_W = 6,
  parameter int RB_W = 5,
  parameter int PH_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  req_kind_e       kind_i,
  input  logic [NB_W-1:0] nout_i,
  input  logic [RB_W-1:0] rbits_i,
  input  logic            tick_i,
  output logic            busy_o,
  output logic            done_o,
  output pins_t           pins_o,
  output logic            shift_o,
  output logic            sample_o
);

  logic            busy_q, busy_d, done_d;
  req_kind_e       kind_q, kind_d;
  logic [PH_W-1:0] ph_q, ph_d, last_ph, tot;
  logic [NB_W-1:0] nout_q, nout_d;
  logic [RB_W-1:0] rb_q, rb_d;
  logic            out_bit, cmd_end_half;
  pins_t           pins_d;

  function automatic pins_t decode(logic b, req_kind_e k, logic [PH_W-1:0] p,
                                   logic [NB_W-1:0] n);
    pins_t r;
    r = PINS_IDLE;
    if (b) begin
      case (k)
        REQ_ENTER: begin
          r.clk   = ~p[0];
          r.rst_n = (p == '0) || (p == PH_W'(5));
          r.oe    = 1'b1;
        end
        REQ_PINRST: begin
          r.rst_n = 1'b0;
          r.oe    = 1'b1;
        end
        default: begin
          r.clk = ~p[0];
          r.oe  = (p >> 1) < PH_W'(n);
        end
      endcase
    end
    return r;
  endfunction

  assign tot     = PH_W'(nout_q) + PH_W'(rb_q);
  assign out_bit = (ph_q >> 1) < PH_W'(nout_q);

  always_comb begin
    case (kind_q)
      REQ_ENTER:  last_ph = PH_W'(5);
      REQ_PINRST: last_ph = '0;
      default:    last_ph = (tot << 1) - PH_W'(1);
    endcase
  end

  // end of a low half-period inside a command
  assign cmd_end_half = busy_q && tick_i && (kind_q == REQ_CMD) && ph_q[0];
  assign shift_o      = cmd_end_half && out_bit;
  assign sample_o     = cmd_end_half && !out_bit;

  always_comb begin
    busy_d = busy_q;
    kind_d = kind_q;
    ph_d   = ph_q;
    nout_d = nout_q;
    rb_d   = rb_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        kind_d = kind_i;
        ph_d   = '0;
        nout_d = nout_i;
        rb_d   = rbits_i;
      end
    end else if (tick_i) begin
      if (ph_q == last_ph) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end
    pins_d = decode(busy_d, kind_d, ph_d, nout_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= REQ_CMD;
      ph_q   <= '0;
      nout_q <= '0;
      rb_q   <= '0;
      done_o <= 1'b0;
      pins_o <= PINS_IDLE;
    end else begin
      busy_q <= busy_d;
      kind_q <= kind_d;
      ph_q   <= ph_d;
      nout_q <= nout_d;
      rb_q   <= rb_d;
      done_o <= done_d;
      pins_o <= pins_d;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/dbg2w_host.sv
module dbg2w_host
  import dbg2w_pkg::*;
#(
  parameter int HP_W   = 24,
  parameter int NARG   = 3,
  parameter int RESP_W = 16,
  localparam int NA_W    = $clog2(NARG + 1),
  localparam int RB_W    = $clog2(RESP_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HP_W-1:0]   half_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [7:0]        req_opcode_i,
  input  logic [8*NARG-1:0] req_args_i,
  input  logic [NA_W-1:0]   req_nargs_i,
  input  logic [RB_W-1:0]   req_rbits_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [RESP_W-1:0] resp_o,
  output logic              dbg_clk_o,
  output logic              dbg_rst_no,
  output logic              dbg_dat_o,
  output logic              dbg_dat_oe_o,
  input  logic              dbg_dat_i
);

  localparam int FRAME_W = 8 * (NARG + 1);
  localparam int NB_W    = $clog2(FRAME_W + 1);
  localparam int PH_W    = $clog2(2 * (FRAME_W + RESP_W) + 1);

  req_kind_e          kind;
  logic               accept, tick, shift, sample, tx_bit;
  logic [NA_W:0]      na_raw, na_eff;
  logic [NB_W-1:0]    nout;
  logic [RB_W-1:0]    rb_eff;
  logic [FRAME_W-1:0] frame;
  pins_t              pins;

  assign kind   = req_kind_e'(req_kind_i);
  assign accept = req_valid_i && !busy_o && (kind != REQ_NONE);

  assign na_raw = (req_opcode_i[7:2] == INJ_PREFIX) ? (NA_W+1)'(req_opcode_i[1:0])
                                                    : (NA_W+1)'(req_nargs_i);
  assign na_eff = (na_raw > (NA_W+1)'(NARG)) ? (NA_W+1)'(NARG) : na_raw;
  assign nout   = NB_W'((na_eff + (NA_W+1)'(1)) * 8);
  assign rb_eff = (req_rbits_i > RB_W'(RESP_W)) ? RB_W'(RESP_W) : req_rbits_i;

  always_comb begin
    frame = '1;
    if (kind == REQ_CMD) begin
      frame[FRAME_W-1 -: 8] = req_opcode_i;
      for (int g = 0; g < NARG; g++)
        frame[FRAME_W-9-8*g -: 8] = req_args_i[8*g +: 8];
    end
  end

  dbg2w_tick #(.HP_W(HP_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .run_i   (busy_o),
    .half_i  (half_i),
    .tick_o  (tick)
  );

  dbg2w_seq #(.NB_W(NB_W), .RB_W(RB_W), .PH_W(PH_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .kind_i   (kind),
    .nout_i   (nout),
    .rbits_i  (rb_eff),
    .tick_i   (tick),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .pins_o   (pins),
    .shift_o  (shift),
    .sample_o (sample)
  );

  dbg2w_shift #(.FRAME_W(FRAME_W), .RESP_W(RESP_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .frame_i  (frame),
    .shift_i  (shift),
    .sample_i (sample),
    .dat_i    (dbg_dat_i),
    .tx_bit_o (tx_bit),
    .rx_o     (resp_o)
  );

  assign dbg_clk_o    = pins.clk;
  assign dbg_rst_no   = pins.rst_n;
  assign dbg_dat_oe_o = pins.oe;
  assign dbg_dat_o    = tx_bit | ~pins.oe;

endmodule

// File: rtl/dbg2w_host_chk.sv
module dbg2w_host_chk #(
  parameter int RESP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [RESP_W-1:0] resp_o,
  input logic              dbg_clk_o,
  input logic              dbg_rst_no,
  input logic              dbg_dat_o,
  input logic              dbg_dat_oe_o
);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_idle_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!dbg_clk_o && dbg_rst_no && !dbg_dat_oe_o));

  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_clk_o && $past(dbg_clk_o)) |-> ($stable(dbg_dat_o) && $stable(dbg_dat_oe_o)));

  p_rst_clk_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dbg_rst_no) |-> !dbg_clk_o);

  p_resp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(resp_o));

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_dat_oe_o |-> dbg_dat_o);

endmodule

bind dbg2w_host dbg2w_host_chk #(.RESP_W(RESP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .resp_o       (resp_o),
  .dbg_clk_o    (dbg_clk_o),
  .dbg_rst_no   (dbg_rst_no),
  .dbg_dat_o    (dbg_dat_o),
  .dbg_dat_oe_o (dbg_dat_oe_o)
);

// File: tb/dbg2w_host_tb.sv
module dbg2w_host_tb;

  localparam int HP_W = 24;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [HP_W-1:0] half_i = '0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_kind_i = '0;
  logic [7:0]  req_opcode_i = '0;
  logic [23:0] req_args_i = '0;
  logic [1:0]  req_nargs_i = '0;
  logic [4:0]  req_rbits_i = '0;
  logic        busy_o, done_o, dbg_clk_o, dbg_rst_no, dbg_dat_o, dbg_dat_oe_o;
  logic [15:0] resp_o;
  logic        dbg_dat_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  dbg2w_host #(.HP_W(HP_W)) u_dut (
    .clk_i, .rst_ni, .half_i, .req_valid_i, .req_kind_i, .req_opcode_i,
    .req_args_i, .req_nargs_i, .req_rbits_i, .busy_o, .done_o, .resp_o,
    .dbg_clk_o, .dbg_rst_no, .dbg_dat_o, .dbg_dat_oe_o, .dbg_dat_i
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic [7:0] op, input logic [23:0] args,
                       input int na, input int rb, input int half);
    half_i       = HP_W'(half);
    req_kind_i   = kind;
    req_opcode_i = op;
    req_args_i   = args;
    req_nargs_i  = 2'(na);
    req_rbits_i  = 5'(rb);
    req_valid_i  = 1'b1;
    @(negedge clk_i);
    req_valid_i  = 1'b0;
  endtask

  task automatic t_reset_state();
    check(!busy_o && !done_o && !dbg_clk_o && dbg_rst_no && !dbg_dat_oe_o && resp_o == 0,
          "R1 reset state", {busy_o, dbg_clk_o, dbg_rst_no, dbg_dat_oe_o}, 4'b0010);
    repeat (20) @(negedge clk_i);
    check(!busy_o && !dbg_clk_o && dbg_rst_no, "R1 quiet without request",
          {busy_o, dbg_clk_o, dbg_rst_no}, 3'b001);
  endtask

  task automatic t_enter(input int half, input bit inject);
    int h, idx, bad, k, late;
    bit ec, er;
    h = (half == 0) ? 1 : half;
    issue(2'd1, 8'h00, 24'h0, 0, 0, half);
    check(busy_o, "R8 busy after accept", busy_o, 1);
    idx = 0; bad = 0;
    while (!done_o && idx < 100 * h) begin
      k  = idx / h;
      ec = (k % 2) == 0;
      er = (k == 0) || (k == 5);
      if (dbg_clk_o != ec || dbg_rst_no != er || !dbg_dat_o || !dbg_dat_oe_o || !busy_o) bad++;
      if (inject && idx == 2) begin
        req_kind_i = 2'd2; req_valid_i = 1'b1;
      end
      if (inject && idx == 3) req_valid_i = 1'b0;
      idx++;
      @(negedge clk_i);
    end
    check(bad == 0, "R2 entry pin sequence", bad, 0);
    check(idx == 6 * h, "R2 entry length", idx, 6 * h);
    @(negedge clk_i);
    check(!done_o && !busy_o, "R8 done single cycle", done_o, 0);
    if (inject) begin
      late = 0;
      for (int i = 0; i < 4 * h + 4; i++) begin
        if (busy_o || !dbg_rst_no) late++;
        @(negedge clk_i);
      end
      check(late == 0, "R8 request while busy ignored", late, 0);
    end
  endtask

  task automatic t_pinrst(input int half);
    int h, idx, bad;
    h = (half == 0) ? 1 : half;
    issue(2'd2, 8'h00, 24'h0, 0, 0, half);
    idx = 0; bad = 0;
    while (!done_o && idx < 100 * h) begin
      if (dbg_rst_no || dbg_clk_o) bad++;
      idx++;
      @(negedge clk_i);
    end
    check(bad == 0 && idx == h, "R3 reset pulse", idx, h);
    check(dbg_rst_no && !dbg_clk_o, "R3 reset released", dbg_rst_no, 1);
  endtask

  task automatic t_cmd(input string tag, input logic [7:0] op, input logic [23:0] args,
                       input int na_in, input int na_exp, input int rb_in, input int rb_exp,
                       input int half, input logic [15:0] pat, input bit chg);
    int h, cyc, nout, nrd, run, badrun, badrst, badoe;
    logic [31:0] outw, expw;
    logic [15:0] expr;
    bit prev;
    h = (half == 0) ? 1 : half;
    expw = 32'(op);
    for (int i = 0; i < na_exp; i++) expw = (expw << 8) | 32'(args[8*i +: 8]);
    expr = (rb_exp == 0) ? 16'h0 : 16'(pat & 16'((32'h1 << rb_exp) - 1));
    issue(2'd0, op, args, na_in, rb_in, half);
    check(busy_o, {tag, " R8 busy after accept"}, busy_o, 1);
    if (chg) half_i = HP_W'(half + 3);
    prev = 1'b0; cyc = 0; nout = 0; nrd = 0; run = 0;
    badrun = 0; badrst = 0; badoe = 0; outw = '0;
    while (!done_o && cyc < 20000) begin
      if (dbg_clk_o != prev) begin
        if (cyc != 0 && run != h) badrun++;
        run = 0;
        if (dbg_clk_o) begin
          if (dbg_dat_oe_o) begin
            outw = {outw[30:0], dbg_dat_o};
            nout++;
          end else begin
            nrd++;
            if (nrd <= rb_exp) dbg_dat_i = pat[rb_exp - nrd];
          end
        end
      end else if (run > 0 && dbg_clk_o && !dbg_dat_oe_o && !dbg_dat_o) begin
        badoe++;
      end
      if (!dbg_rst_no) badrst++;
      run++;
      prev = dbg_clk_o;
      cyc++;
      @(negedge clk_i);
    end
    check(nout == 8 * (na_exp + 1), {tag, " R4 R6 bits sent"}, nout, 8 * (na_exp + 1));
    check(outw == expw, {tag, " R4 R6 sent value"}, outw, expw);
    check(badrst == 0 && badoe == 0, {tag, " R4 R5 rst/data release"}, badrst + badoe, 0);
    check(badrun == 0, {tag, " R7 half-period length"}, badrun, 0);
    check(nrd == rb_exp, {tag, " R5 R9 bits read"}, nrd, rb_exp);
    check(resp_o == expr, {tag, " R5 R9 response"}, resp_o, expr);
    dbg_dat_i = 1'b1;
    @(negedge clk_i);
    check(!done_o && !busy_o, {tag, " R8 done single cycle"}, done_o, 0);
  endtask

  task automatic t_kind3();
    int bad;
    issue(2'd3, 8'h68, 24'h0, 0, 8, 2);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (busy_o || dbg_clk_o || !dbg_rst_no) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, "R8 R1 kind 3 ignored", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_enter(3, 1'b0);
    t_enter(2, 1'b1);
    t_pinrst(4);
    t_cmd("chipid",  8'h68, 24'h0,      0, 0, 16, 16, 2, 16'hA5C3, 1'b0);
    t_cmd("cfgwr",   8'h1D, 24'h22,     1, 1, 8,  8,  3, 16'h005A, 1'b1);
    t_cmd("inject3", 8'h57, 24'hFE0275, 0, 3, 8,  8,  1, 16'h0081, 1'b0);
    t_cmd("inject0", 8'h54, 24'h123456, 3, 0, 8,  8,  2, 16'h00C4, 1'b0);
    t_cmd("clamp",   8'h34, 24'h0,      0, 0, 20, 16, 1, 16'h9E37, 1'b0);
    t_cmd("noread",  8'h24, 24'h0,      0, 0, 0,  0,  0, 16'hFFFF, 1'b0);
    t_cmd("twoargs", 8'h44, 24'h00B7E1, 2, 2, 5,  5,  2, 16'h0013, 1'b1);
    t_kind3();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule